// File: doc/BRIEF.md
# Page Write Buffer with Upper-Half Write Protection

This block sits between a two-wire bus slave decoder and a 256-byte non-volatile array. The decoder hands it a word address, then a stream of data bytes. The block gathers those bytes in a 16-slot page buffer. Only the low four bits of the pointer advance, so a long burst wraps inside the addressed page. When the decoder reports a Stop, the block drains the buffer into the array write port and runs a self-timed write cycle. The array itself is outside this block; only its write port is driven here.

A write-protect level, sampled on the Stop cycle, blocks every write whose address lies in the upper half of the array. A protected transaction is still accepted and still runs the full timed cycle, but it produces no write strobes. The `busy` output stays high for the whole timed cycle. The decoder uses it to withhold acknowledges, which is how a bus master polls for completion. A repeated Start before any Stop arrives on the abort strobe; it discards the buffer and starts no cycle.

Top module: `page_write_buffer`

## Requirements
- R1: During and directly after reset, `busy` and `mem_we` are low and no write is issued.
- R2: A Stop that arrives after at least one accepted data byte starts a commit. Each received byte is written with `mem_addr` = {page, slot}, where page is bits 7:4 of the loaded address. A single-byte write is the one-slot case.
- R3: A commit writes the filled slots lowest slot index first, and writes them on consecutive clocks.
- R4: Each accepted data byte advances only the low four pointer bits. After offset 15 the next byte goes to offset 0 of the same page.
- R5: If more than 16 bytes arrive before the Stop, a later byte replaces the earlier byte held in the same slot. Only the final value of each slot is written.
- R6: If `wp` is high on the Stop cycle, no write is issued to addresses 0x80 to 0xFF. Addresses 0x00 to 0x7F are always writable. With `wp` low on the Stop cycle, every address is writable.
- R7: After a committing Stop, `busy` goes high from the next clock and stays high for exactly WR_CYCLES clocks. This holds even when every byte was protected.
- R8: A Stop with no accepted data byte since the last commit or abort leaves `busy` low and writes nothing.
- R9: An abort strobe empties the buffer. A later Stop then writes nothing and starts no cycle.
- R10: When abort and Stop arrive in the same clock, the abort wins: no cycle starts and the buffer is emptied.
- R11: While `busy` is high, the address-load, data, Stop and abort strobes are all ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_load | input | 1 | One-clock strobe: load the word pointer from `load_addr` |
| load_addr | input | 8 | Word address; bits 7:4 select the page, bits 3:0 the slot |
| data_stb | input | 1 | One-clock strobe: store `data_in` at the current slot |
| data_in | input | 8 | Data byte received from the bus |
| stop_stb | input | 1 | One-clock strobe: a Stop condition was seen |
| abort_stb | input | 1 | One-clock strobe: a repeated Start arrived before any Stop |
| wp | input | 1 | Write-protect level for the upper half of the array |
| mem_we | output | 1 | Array write enable, registered |
| mem_addr | output | 8 | Array write address, registered |
| mem_wdata | output | 8 | Array write data, registered |
| busy | output | 1 | Timed write cycle in progress; no acknowledge may be given |

## Verification
Abort and Stop can both arrive in the same clock, and each one alone would change the buffer in a different way. The bench drives the two strobes high together, directly after filling a slot. It then requires that `busy` stays low and that no write strobe appears. A second, lone Stop must also leave the block idle, which shows that the buffer was emptied rather than kept for later. A related overlap occurs when new strobes arrive during the timed cycle. The bench sends a load, a data byte, an abort and a Stop while `busy` is high. After the cycle ends, it shows that the pointer and the buffer were left untouched.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic [1:0] {
    DRN_IDLE  = 2'd0,
    DRN_WRITE = 2'd1
  } drain_state_t;

endpackage

// File: rtl/pwb_pointer.sv
module pwb_pointer #(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 4,
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  output logic [PAGE_W-1:0] page,
  output logic [OFF_W-1:0]  off
);

  logic [PAGE_W-1:0] page_q;
  logic [OFF_W-1:0]  off_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      off_q  <= '0;
    end else if (load) begin
      page_q <= load_addr[ADDR_W-1:OFF_W];
      off_q  <= load_addr[OFF_W-1:0];
    end else if (step) begin
      // the page field never changes here: the offset wraps inside the page
      off_q <= off_q + 1'b1;
    end
  end

  assign page = page_q;
  assign off  = off_q;

endmodule

// File: rtl/pwb_page_buf.sv
module pwb_page_buf #(
  parameter int DATA_W = 8,
  parameter int SLOTS  = 16,
  localparam int OFF_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_en,
  input  logic [OFF_W-1:0]  fill_slot,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              flush,
  input  logic              retire_en,
  input  logic [OFF_W-1:0]  retire_slot,
  input  logic [OFF_W-1:0]  rd_slot,
  output logic [DATA_W-1:0] rd_data,
  output logic [SLOTS-1:0]  slot_full
);

  logic [DATA_W-1:0] store_q [SLOTS];
  logic [SLOTS-1:0]  full_q;

  // data storage kept free of reset so it can map onto distributed RAM
  always_ff @(posedge clk) begin
    if (fill_en) store_q[fill_slot] <= fill_data;
  end

  genvar gi;
  generate
    for (gi = 0; gi < SLOTS; gi++) begin : g_flag
      always_ff @(posedge clk) begin
        if (rst || flush) begin
          full_q[gi] <= 1'b0;
        end else if (fill_en && fill_slot == OFF_W'(gi)) begin
          full_q[gi] <= 1'b1;
        end else if (retire_en && retire_slot == OFF_W'(gi)) begin
          full_q[gi] <= 1'b0;
        end
      end
    end
  endgenerate

  assign rd_data   = store_q[rd_slot];
  assign slot_full = full_q;

endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
  parameter int WR_CYCLES = 625000,
  localparam int CNT_W = $clog2(WR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);

  logic [CNT_W-1:0] left_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      left_q <= CNT_W'(WR_CYCLES - 1);
    end else if (busy_q) begin
      if (left_q == '0) busy_q <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/pwb_drain.sv
module pwb_drain
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SLOTS  = 16,
  localparam int OFF_W  = $clog2(SLOTS),
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wp,
  input  logic [PAGE_W-1:0] page,
  input  logic [SLOTS-1:0]  slot_full,
  input  logic [DATA_W-1:0] rd_data,
  output logic [OFF_W-1:0]  rd_slot,
  output logic              retire_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);

  drain_state_t      state_q;
  logic              guard_q;
  logic [OFF_W-1:0]  pick;
  logic              any_full;
  logic              blocked;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  // lowest filled slot wins
  always_comb begin
    pick = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (slot_full[i]) pick = OFF_W'(i);
    end
  end

  assign any_full  = |slot_full;
  // protected region is the upper half of the array: page MSB set
  assign blocked   = guard_q && page[PAGE_W-1];
  assign rd_slot   = pick;
  assign retire_en = (state_q == DRN_WRITE) && any_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= DRN_IDLE;
      guard_q <= 1'b0;
    end else begin
      case (state_q)
        DRN_IDLE: if (start) begin
          state_q <= DRN_WRITE;
          guard_q <= wp;
        end
        DRN_WRITE: if (!any_full) state_q <= DRN_IDLE;
        default: state_q <= DRN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      we_q <= retire_en && !blocked;
      if (retire_en) begin
        addr_q  <= {page, pick};
        wdata_q <= rd_data;
      end
    end
  end

  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wdata_q;

endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 16,
  parameter int WR_CYCLES  = 625000,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int PAGE_W = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              data_stb,
  input  logic [DATA_W-1:0] data_in,
  input  logic              stop_stb,
  input  logic              abort_stb,
  input  logic              wp,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              busy
);

  logic                  open;
  logic                  take_load, take_data, take_abort, take_stop, kick;
  logic [PAGE_W-1:0]     page;
  logic [OFF_W-1:0]      off;
  logic [PAGE_BYTES-1:0] slot_full;
  logic [OFF_W-1:0]      rd_slot;
  logic [DATA_W-1:0]     rd_data;
  logic                  retire_en;

  assign open       = !busy;
  assign take_load  = addr_load && open;
  assign take_data  = data_stb && open;
  assign take_abort = abort_stb && open;
  assign take_stop  = stop_stb && open && !abort_stb;
  assign kick       = take_stop && (|slot_full);

  pwb_pointer #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_ptr (
    .clk(clk), .rst(rst), .load(take_load), .load_addr(load_addr),
    .step(take_data), .page(page), .off(off)
  );

  pwb_page_buf #(.DATA_W(DATA_W), .SLOTS(PAGE_BYTES)) u_buf (
    .clk(clk), .rst(rst), .fill_en(take_data), .fill_slot(off),
    .fill_data(data_in), .flush(take_abort), .retire_en(retire_en),
    .retire_slot(rd_slot), .rd_slot(rd_slot), .rd_data(rd_data),
    .slot_full(slot_full)
  );

  pwb_drain #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOTS(PAGE_BYTES)) u_drain (
    .clk(clk), .rst(rst), .start(kick), .wp(wp), .page(page),
    .slot_full(slot_full), .rd_data(rd_data), .rd_slot(rd_slot),
    .retire_en(retire_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  pwb_cycle_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(kick), .busy(busy)
  );

endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int ADDR_W    = 8,
  parameter int OFF_W     = 4,
  parameter int WR_CYCLES = 625000
) (
  input logic              clk,
  input logic              rst,
  input logic              addr_load,
  input logic [ADDR_W-1:0] load_addr,
  input logic              data_stb,
  input logic              stop_stb,
  input logic              abort_stb,
  input logic              wp,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              busy
);

  logic [31:0]             run_q;
  logic [ADDR_W-OFF_W-1:0] page_q;
  logic                    guard_q;
  logic                    held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      page_q  <= '0;
      guard_q <= 1'b0;
      held_q  <= 1'b0;
    end else begin
      run_q <= busy ? run_q + 1 : '0;
      if (addr_load && !busy) page_q <= load_addr[ADDR_W-1:OFF_W];
      if (stop_stb && !busy && !abort_stb) guard_q <= wp;
      if (!busy) begin
        if (abort_stb || stop_stb) held_q <= 1'b0;
        else if (data_stb)         held_q <= 1'b1;
      end
    end
  end

  initial begin
    // R7
    cycle_room_chk: assert (WR_CYCLES > (1 << OFF_W) + 1);
  end

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> run_q == WR_CYCLES);

  // R2
  we_in_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  // R2
  start_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_stb && !abort_stb && !busy && held_q) |=> busy);

  // R8
  empty_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (stop_stb && !busy && !held_q) |=> !busy);

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    (abort_stb && !busy) |=> !busy);

  // R4
  same_page_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_addr[ADDR_W-1:OFF_W] == page_q);

  // R6
  protect_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && guard_q) |-> !mem_addr[ADDR_W-1]);

  // R3
  ascend_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> mem_addr > $past(mem_addr));

endmodule

bind page_write_buffer pwb_checker #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .WR_CYCLES(WR_CYCLES)
) u_pwb_checker (
  .clk(clk), .rst(rst), .addr_load(addr_load), .load_addr(load_addr),
  .data_stb(data_stb), .stop_stb(stop_stb), .abort_stb(abort_stb), .wp(wp),
  .mem_we(mem_we), .mem_addr(mem_addr), .busy(busy)
);

// File: tb/page_write_buffer_bench.sv
`timescale 1ns/1ps
module page_write_buffer_bench;

  localparam int CYC = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld = 1'b0, dstb = 1'b0, stp = 1'b0, abt = 1'b0, wp = 1'b0;
  logic [7:0] ld_addr = '0, din = '0;
  logic       mem_we, busy;
  logic [7:0] mem_addr, mem_wdata;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0] q_addr [$];
  logic [7:0] q_data [$];
  string      q_tag  [$];

  logic [3:0] m_page = '0, m_off = '0;
  logic       m_full [16];
  logic [7:0] m_byte [16];

  always #4 clk = ~clk;

  page_write_buffer #(.WR_CYCLES(CYC)) u_page_write_buffer (
    .clk(clk), .rst(rst), .addr_load(ld), .load_addr(ld_addr),
    .data_stb(dstb), .data_in(din), .stop_stb(stp), .abort_stb(abt),
    .wp(wp), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .busy(busy)
  );

  task automatic check(string rq, bit ok, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as writes appear
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (q_addr.size() == 0) begin
        check("R6/R8/R9/R11 unexpected write", 0, {mem_addr, mem_wdata}, 0);
      end else begin
        logic [7:0] ea, ed;
        string t;
        ea = q_addr.pop_front();
        ed = q_data.pop_front();
        t  = q_tag.pop_front();
        check({t, " addr"}, mem_addr == ea, mem_addr, ea);
        check({t, " data"}, mem_wdata == ed, mem_wdata, ed);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_load(logic [7:0] a);
    ld = 1; ld_addr = a; tick(); ld = 0;
    m_page = a[7:4]; m_off = a[3:0];
  endtask

  task automatic do_put(logic [7:0] d);
    dstb = 1; din = d; tick(); dstb = 0;
    m_byte[m_off] = d; m_full[m_off] = 1; m_off = m_off + 1;
  endtask

  task automatic clear_model();
    for (int i = 0; i < 16; i++) m_full[i] = 0;
  endtask

  task automatic do_stop(string rq);
    stp = 1; tick(); stp = 0;
    for (int i = 0; i < 16; i++) begin
      if (m_full[i] && !(wp && m_page[3])) begin
        q_addr.push_back({m_page, 4'(i)});
        q_data.push_back(m_byte[i]);
        q_tag.push_back(rq);
      end
    end
    clear_model();
  endtask

  task automatic run_commit(string rq);
    int cnt = 0;
    do_stop(rq);
    forever begin
      @(negedge clk);
      if (busy && cnt < 1000) cnt++;
      else break;
    end
    check({rq, " R7 busy length"}, cnt == CYC, cnt, CYC);
    check({rq, " all writes seen"}, q_addr.size() == 0, q_addr.size(), 0);
    tick();
  endtask

  task automatic expect_idle(string rq);
    repeat (3) @(negedge clk);
    check({rq, " busy stays low"}, busy == 0, busy, 0);
    tick();
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!finished) begin
      check("watchdog", 0, 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    clear_model();
    repeat (4) tick();
    @(negedge clk);
    check("R1 busy in reset", busy == 0, busy, 0);
    check("R1 we in reset", mem_we == 0, mem_we, 0);
    tick();
    rst = 0;
    tick();
    check("R1 busy after reset", busy == 0, busy, 0);

    // R2 single byte
    do_load(8'h12); do_put(8'hA5); run_commit("R2");

    // R3 full page, ascending slots
    do_load(8'h30);
    for (int i = 0; i < 16; i++) do_put(8'h40 + 8'(i));
    run_commit("R3");

    // R4 wrap inside page
    do_load(8'h4E);
    for (int i = 0; i < 4; i++) do_put(8'hC0 + 8'(i));
    run_commit("R4");

    // R5 overrun: 18 bytes
    do_load(8'h50);
    for (int i = 0; i < 18; i++) do_put(8'h10 + 8'(i));
    run_commit("R5");

    // R6/R7 protected upper page, full cycle still runs
    wp = 1;
    do_load(8'h80);
    for (int i = 0; i < 3; i++) do_put(8'h99);
    run_commit("R6 R7 protected");
    do_load(8'h20); do_put(8'h21); do_put(8'h22); run_commit("R6 lower half");
    wp = 0;
    do_load(8'hF0); do_put(8'hF1); do_put(8'hF2); run_commit("R6 wp low");

    // R6 wp level taken on the Stop cycle
    do_load(8'hA0); do_put(8'h5A);
    wp = 1;
    run_commit("R6 wp at stop");
    wp = 0;

    // R8 stop with nothing buffered
    do_stop("R8"); expect_idle("R8");

    // R9 abort discards
    do_load(8'h60); do_put(8'h61); do_put(8'h62);
    abt = 1; tick(); abt = 0; clear_model();
    do_stop("R9"); expect_idle("R9");

    // R10 abort and stop together
    do_load(8'h64); do_put(8'h65);
    abt = 1; stp = 1; tick(); abt = 0; stp = 0; clear_model();
    expect_idle("R10 coincident");
    do_stop("R10"); expect_idle("R10 after");

    // R11 strobes ignored while busy
    do_load(8'h10); do_put(8'h11);
    stp = 1; tick(); stp = 0;
    q_addr.push_back(8'h10); q_data.push_back(8'h11); q_tag.push_back("R11 first");
    clear_model();
    tick();
    ld = 1; ld_addr = 8'h90; tick(); ld = 0;
    dstb = 1; din = 8'h77; tick(); dstb = 0;
    abt = 1; tick(); abt = 0;
    stp = 1; tick(); stp = 0;
    while (busy) tick();
    expect_idle("R11");
    check("R11 queue drained", q_addr.size() == 0, q_addr.size(), 0);
    do_put(8'h55); run_commit("R11 pointer kept");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule